// File: doc/BRIEF.md
# Write Burst Timing Controller

This block sits on the controller side of a double-data-rate memory interface and turns write and read requests into a clean command stream. Each request carries a bank, a column and an on-the-fly chop bit (address bit A12). Three programmable inputs set the burst rule, the additive latency and the CAS write latency. For every accepted write, the block picks a burst length and schedules three strobe phases at fixed clock offsets from the command: the preamble, the data clocks and the postamble.

Data is counted in clock cycles. Each data clock carries two beats, so an 8-beat burst fills four data clocks and a 4-beat chop fills two. After the last data clock a turnaround timer runs. A read arriving too soon is held on a valid/ready handshake until the timer allows it. Writes own a fixed four-clock data slot, so a following write waits until that slot and its postamble have passed. The CAS write latency must be at least 2.

Top module: `wbt_write_timing`

## Requirements
- R1: The write latency WL is cfg_al + cfg_cwl. After a WRITE is issued in clock 0, the first data clock is clock WL.
- R2: With cfg_burst_mode = 00, every command is an 8-beat burst: cmd_bl8 = 1 and four data clocks.
- R3: With cfg_burst_mode = 01, req_a12 = 1 selects an 8-beat burst and req_a12 = 0 selects a 4-beat chop (cmd_bl8 = 0, two data clocks). This holds for reads and for writes.
- R4: With cfg_burst_mode = 10, every command is a 4-beat chop with two data clocks. Mode 11 behaves like mode 00.
- R5: In the i-th data clock (i counted from 0), dq_col equals the command column plus 2*i, modulo the column width.
- R6: dqs_pre is high only in clock WL-1, one clock before the first data clock. dqs_post is high only in the clock right after the last data clock. At most one of dqs_pre, dq_valid and dqs_post is high in any clock.
- R7: Let L be the last data clock of a write. A read cannot issue before clock L+1+cfg_twtr, and it issues in that clock if it is already waiting. Until then req_ready stays low for the read.
- R8: A held read is not dropped. It issues with the bank and column it was presented with.
- R9: cmd_code is 00 for NOP, 01 for WRITE and 10 for READ. Any clock without an accepted request shows NOP, and no more than one command appears per clock.
- R10: A write issued in clock 0 keeps write requests blocked (req_ready low) through clock WL+4, for both burst lengths. A new write is accepted from clock WL+5.
- R11: During and directly after reset, cmd_code is NOP, dqs_pre, dq_valid and dqs_post are low, and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_burst_mode | input | 2 | Burst rule: 00 fixed 8, 01 per-command via A12, 10 fixed chop 4, 11 fixed 8 |
| cfg_al | input | LAT_W | Additive latency in clocks |
| cfg_cwl | input | LAT_W | CAS write latency in clocks (at least 2) |
| cfg_twtr | input | TMR_W | Write-to-read turnaround in clocks |
| req_valid | input | 1 | Request present |
| req_read | input | 1 | 1 for read, 0 for write |
| req_bank | input | BANK_W | Bank address |
| req_col | input | COL_W | Start column |
| req_a12 | input | 1 | On-the-fly chop bit |
| req_ready | output | 1 | Request accepted this clock when valid |
| cmd_code | output | 2 | Command issued this clock (00 NOP, 01 WRITE, 10 READ) |
| cmd_bank | output | BANK_W | Bank of the issued command, 0 on NOP |
| cmd_col | output | COL_W | Column of the issued command, 0 on NOP |
| cmd_bl8 | output | 1 | 1 when the issued command is an 8-beat burst |
| dqs_pre | output | 1 | Strobe preamble clock |
| dq_valid | output | 1 | Data clock (two beats) |
| dq_col | output | COL_W | Column of the first beat in this data clock |
| dqs_post | output | 1 | Strobe postamble clock |

## Verification
Two events can coincide: the turnaround timer reaching zero and a waiting read being granted. The bench provokes this by presenting a read right after a write and holding it. It then checks that the READ appears in exactly clock L+1+cfg_twtr, no earlier and no later, with zero, small and moderate turnaround values under both burst lengths. A second overlap is the postamble of a chop, which falls inside the still-open write slot. The bench judges it by sampling dqs_post and req_ready in the same clock.

// File: rtl/wbt_pkg.sv
package wbt_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_WRITE = 2'b01,
    CMD_READ  = 2'b10
  } cmd_e;

  // Burst rule: 01 follows the chop bit, 10 forces the chop, others use the full burst.
  function automatic logic pick_bl8(input logic [1:0] mode, input logic a12);
    case (mode)
      2'b01:   pick_bl8 = a12;
      2'b10:   pick_bl8 = 1'b0;
      default: pick_bl8 = 1'b1;
    endcase
  endfunction

  // Clocks that carry data: two beats per clock.
  function automatic logic [2:0] data_clocks(input logic bl8);
    data_clocks = bl8 ? 3'd4 : 3'd2;
  endfunction

endpackage

// File: rtl/wbt_write_sched.sv
module wbt_write_sched #(
  parameter int LAT_W = 4,
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LAT_W:0]   wl,
  input  logic             bl8,
  input  logic [COL_W-1:0] col,
  output logic             busy,
  output logic             pending,
  output logic             pre,
  output logic             dv,
  output logic [COL_W-1:0] dcol,
  output logic             last,
  output logic             post,
  output logic             bl8_cur
);
  localparam int CNT_W = LAT_W + 2;

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [LAT_W:0]   wl_q;
  logic             bl8_q;
  logic [COL_W-1:0] col_q;

  logic [CNT_W-1:0] wl_e, end_idx, slot_end, offs;

  always_comb begin
    wl_e     = CNT_W'(wl_q);
    end_idx  = wl_e + CNT_W'(wbt_pkg::data_clocks(bl8_q)) - CNT_W'(1);
    slot_end = wl_e + CNT_W'(4);
    offs     = cnt_q - wl_e;
    pre      = busy_q && (cnt_q == wl_e - CNT_W'(1));
    dv       = busy_q && (cnt_q >= wl_e) && (cnt_q <= end_idx);
    last     = busy_q && (cnt_q == end_idx);
    post     = busy_q && (cnt_q == end_idx + CNT_W'(1));
    pending  = busy_q && (cnt_q <= end_idx);
    dcol     = dv ? col_q + COL_W'({offs, 1'b0}) : '0;
  end

  assign busy    = busy_q;
  assign bl8_cur = bl8_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      wl_q   <= '0;
      bl8_q  <= 1'b0;
      col_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(1);
      wl_q   <= wl;
      bl8_q  <= bl8;
      col_q  <= col;
    end else if (busy_q) begin
      if (cnt_q == slot_end) busy_q <= 1'b0;
      else                   cnt_q  <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/wbt_turnaround.sv
module wbt_turnaround #(
  parameter int TMR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] tval,
  output logic             zero
);
  logic [TMR_W-1:0] t_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          t_q <= '0;
    else if (load)       t_q <= tval;
    else if (t_q != '0)  t_q <= t_q - TMR_W'(1);
  end

  assign zero = (t_q == '0);
endmodule

// File: rtl/wbt_write_timing.sv
module wbt_write_timing #(
  parameter int LAT_W  = 4,
  parameter int TMR_W  = 4,
  parameter int BANK_W = 3,
  parameter int COL_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_burst_mode,
  input  logic [LAT_W-1:0]  cfg_al,
  input  logic [LAT_W-1:0]  cfg_cwl,
  input  logic [TMR_W-1:0]  cfg_twtr,
  input  logic              req_valid,
  input  logic              req_read,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_a12,
  output logic              req_ready,
  output logic [1:0]        cmd_code,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [COL_W-1:0]  cmd_col,
  output logic              cmd_bl8,
  output logic              dqs_pre,
  output logic              dq_valid,
  output logic [COL_W-1:0]  dq_col,
  output logic              dqs_post
);
  import wbt_pkg::*;

  function automatic logic [LAT_W:0] write_lat(input logic [LAT_W-1:0] al,
                                               input logic [LAT_W-1:0] cwl);
    write_lat = {1'b0, al} + {1'b0, cwl};
  endfunction

  // Named internal events for the checker.
  logic wr_busy, wr_pending, wr_last, wr_bl8_cur, tmr_zero;
  logic req_bl8, wr_ok, rd_ok, issue, wr_start;

  assign req_bl8   = pick_bl8(cfg_burst_mode, req_a12);
  assign wr_ok     = !wr_busy;
  assign rd_ok     = !wr_pending && tmr_zero;
  assign req_ready = req_read ? rd_ok : wr_ok;
  assign issue     = req_valid && req_ready;
  assign wr_start  = issue && !req_read;

  always_comb begin
    cmd_code = CMD_NOP;
    if (issue) cmd_code = req_read ? CMD_READ : CMD_WRITE;
    cmd_bank = issue ? req_bank : '0;
    cmd_col  = issue ? req_col  : '0;
    cmd_bl8  = issue && req_bl8;
  end

  wbt_write_sched #(.LAT_W(LAT_W), .COL_W(COL_W)) u_sched (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (wr_start),
    .wl      (write_lat(cfg_al, cfg_cwl)),
    .bl8     (req_bl8),
    .col     (req_col),
    .busy    (wr_busy),
    .pending (wr_pending),
    .pre     (dqs_pre),
    .dv      (dq_valid),
    .dcol    (dq_col),
    .last    (wr_last),
    .post    (dqs_post),
    .bl8_cur (wr_bl8_cur)
  );

  wbt_turnaround #(.TMR_W(TMR_W)) u_twtr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (wr_last),
    .tval  (cfg_twtr),
    .zero  (tmr_zero)
  );
endmodule

// File: rtl/wbt_checker.sv
module wbt_checker #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [1:0]       cmd_code,
  input logic             dqs_pre,
  input logic             dq_valid,
  input logic [COL_W-1:0] dq_col,
  input logic             dqs_post,
  input logic             wr_last,
  input logic             wr_pending,
  input logic             wr_busy,
  input logic             wr_bl8_cur,
  input logic             tmr_zero
);
  assert_nop_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> cmd_code == 2'b00);

  assert_pre_leads_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_pre |=> dq_valid);

  assert_post_follows_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_last |=> dqs_post && !dq_valid);

  assert_single_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dqs_pre, dq_valid, dqs_post}));

  assert_col_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dq_valid && $past(dq_valid) |-> dq_col == $past(dq_col) + COL_W'(2));

  assert_read_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_code == 2'b10 |-> !wr_pending && tmr_zero);

  assert_write_slot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_code == 2'b01 |=> wr_busy && !dq_valid);

  assert_chop_short_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dq_valid && $past(dq_valid) && !wr_bl8_cur |-> wr_last);
endmodule

bind wbt_write_timing wbt_checker #(.COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .cmd_code   (cmd_code),
  .dqs_pre    (dqs_pre),
  .dq_valid   (dq_valid),
  .dq_col     (dq_col),
  .dqs_post   (dqs_post),
  .wr_last    (wr_last),
  .wr_pending (wr_pending),
  .wr_busy    (wr_busy),
  .wr_bl8_cur (wr_bl8_cur),
  .tmr_zero   (tmr_zero)
);

// File: tb/tb_wbt_write_timing.sv
module tb_wbt_write_timing;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_burst_mode = 2'b00;
  logic [3:0] cfg_al = 4'd0, cfg_cwl = 4'd5, cfg_twtr = 4'd0;
  logic       req_valid = 1'b0, req_read = 1'b0, req_a12 = 1'b0;
  logic [2:0] req_bank = '0;
  logic [9:0] req_col = '0;
  logic       req_ready, cmd_bl8, dqs_pre, dq_valid, dqs_post;
  logic [1:0] cmd_code;
  logic [2:0] cmd_bank;
  logic [9:0] cmd_col, dq_col;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wbt_write_timing dut (
    .clk(clk), .rst_n(rst_n), .cfg_burst_mode(cfg_burst_mode), .cfg_al(cfg_al),
    .cfg_cwl(cfg_cwl), .cfg_twtr(cfg_twtr), .req_valid(req_valid), .req_read(req_read),
    .req_bank(req_bank), .req_col(req_col), .req_a12(req_a12), .req_ready(req_ready),
    .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cmd_bl8(cmd_bl8),
    .dqs_pre(dqs_pre), .dq_valid(dq_valid), .dq_col(dq_col), .dqs_post(dqs_post)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // R11: reset state
  task automatic t_reset();
    @(negedge clk); #1;
    chk(cmd_code == 2'b00 && !dqs_pre && !dq_valid && !dqs_post, "R11", "outputs in reset",
        {cmd_code, dqs_pre, dq_valid, dqs_post}, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(req_ready && cmd_code == 2'b00 && !dq_valid, "R11", "ready after reset",
        req_ready, 1);
  endtask

  // R9: no valid request gives NOP even with a read pattern on the other inputs
  task automatic t_nop();
    req_read = 1'b1; req_bank = 3'd6; req_col = 10'h155;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk(cmd_code == 2'b00 && cmd_bank == 0 && cmd_col == 0, "R9", "NOP without valid",
          cmd_code, 0);
    end
    req_read = 1'b0;
  endtask

  // Issue a write, then compare every clock of its slot (R1 R5 R6 R10).
  task automatic t_write(input string tag, input logic [1:0] mode, input logic a12,
                         input int al, input int cwl, input int col, input bit exp_bl8);
    int wl, n, ok;
    wl = al + cwl; n = exp_bl8 ? 4 : 2;
    cfg_burst_mode = mode; cfg_al = 4'(al); cfg_cwl = 4'(cwl);
    @(negedge clk);
    req_valid = 1'b1; req_read = 1'b0; req_a12 = a12; req_col = 10'(col); req_bank = 3'd2;
    #1;
    chk(cmd_code == 2'b01 && cmd_col == 10'(col) && cmd_bank == 3'd2, "R9", "write issued",
        cmd_code, 1);
    chk(cmd_bl8 == exp_bl8, tag, "burst length flag", cmd_bl8, int'(exp_bl8));
    for (int k = 1; k <= wl + 5; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      ok = (dqs_pre == (k == wl - 1));
      chk(ok, "R6", $sformatf("preamble at k=%0d", k), dqs_pre, int'(k == wl - 1));
      ok = (dq_valid == (k >= wl && k < wl + n));
      chk(ok, (k == wl) ? "R1" : tag, $sformatf("data valid at k=%0d", k), dq_valid,
          int'(k >= wl && k < wl + n));
      if (k >= wl && k < wl + n)
        chk(dq_col == 10'(col + 2 * (k - wl)), "R5", $sformatf("column at k=%0d", k),
            dq_col, (col + 2 * (k - wl)) & 10'h3ff);
      chk(dqs_post == (k == wl + n), "R6", $sformatf("postamble at k=%0d", k), dqs_post,
          int'(k == wl + n));
      chk(req_ready == (k >= wl + 5), "R10", $sformatf("write ready at k=%0d", k),
          req_ready, int'(k >= wl + 5));
    end
  endtask

  // Write then an early read held until the turnaround ends (R7 R8).
  task automatic t_turn(input logic [1:0] mode, input logic a12, input int al, input int cwl,
                        input int twtr, input int exp_k);
    int k; bit nop_ok;
    cfg_burst_mode = mode; cfg_al = 4'(al); cfg_cwl = 4'(cwl); cfg_twtr = 4'(twtr);
    @(negedge clk);
    req_valid = 1'b1; req_read = 1'b0; req_a12 = a12; req_col = 10'h010;
    @(negedge clk);
    req_read = 1'b1; req_bank = 3'd5; req_col = 10'h3f0;
    k = 1; nop_ok = 1'b1;
    #1;
    while (cmd_code != 2'b10 && k < 100) begin
      if (cmd_code != 2'b00 || req_ready) nop_ok = 1'b0;
      @(negedge clk); k++; #1;
    end
    chk(nop_ok, "R7", "held read shows NOP and not ready", int'(nop_ok), 1);
    chk(k == exp_k, "R7", "read issue clock", k, exp_k);
    chk(cmd_bank == 3'd5 && cmd_col == 10'h3f0, "R8", "held read address", cmd_col, 10'h3f0);
    chk(cmd_bl8 == (mode == 2'b00 || (mode == 2'b01 && a12)), "R3", "read burst flag",
        cmd_bl8, int'(mode == 2'b00 || (mode == 2'b01 && a12)));
    @(negedge clk);
    req_valid = 1'b0; req_read = 1'b0;
    idle(8);
  endtask

  // Read with nothing pending issues at once (R3 chop on a read).
  task automatic t_read_now();
    cfg_burst_mode = 2'b01; cfg_twtr = 4'd0;
    idle(4);
    req_valid = 1'b1; req_read = 1'b1; req_a12 = 1'b0; req_bank = 3'd1; req_col = 10'h022;
    #1;
    chk(cmd_code == 2'b10 && cmd_col == 10'h022, "R8", "immediate read", cmd_code, 2);
    chk(cmd_bl8 == 1'b0, "R3", "chop on read", cmd_bl8, 0);
    @(negedge clk);
    req_valid = 1'b0; req_read = 1'b0;
    idle(2);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_nop();
    cfg_twtr = 4'd0;
    t_write("R2", 2'b00, 1'b0, 4, 5, 10'h100, 1'b1);
    t_write("R3", 2'b01, 1'b1, 0, 5, 10'h3fc, 1'b1);
    t_write("R3", 2'b01, 1'b0, 2, 3, 10'h040, 1'b0);
    t_write("R4", 2'b10, 1'b1, 1, 6, 10'h008, 1'b0);
    t_write("R4", 2'b11, 1'b0, 0, 2, 10'h0a0, 1'b1);
    t_turn(2'b00, 1'b0, 0, 5, 3, 12);
    t_turn(2'b10, 1'b0, 1, 5, 0, 8);
    t_turn(2'b01, 1'b0, 2, 4, 2, 10);
    t_turn(2'b01, 1'b1, 0, 4, 5, 13);
    t_read_now();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule